// File: doc/BRIEF.md
# Prefetch Address Breakpoint

This block watches the instruction-prefetch address bus of a CPU. It raises an interrupt request when a fetch reaches an address that software has programmed as a breakpoint. Software sets the breakpoint address and an enable bit through a byte-wide register port. The block compares every strobed prefetch against that address. On a hit it sets a sticky flag, and that flag drives a level request to the interrupt controller. The CPU's mask bits cannot block this request.

The compare ignores address bit 0, so a breakpoint covers a halfword. An input selects the addressing mode. In advanced mode address bits 23 down to 1 are compared. In normal mode only bits 15 down to 1 are compared. Any strobed prefetch counts as a hit, including a speculative fetch issued just after a branch or return. Software clears the flag with a two-step handshake: it reads the flag as 1, then writes 0 to it.

Top module: `pbrk_top`

## Requirements
- R1: After a synchronous active-low reset, the three address bytes, the enable bit and the flag are all 0. `irq` is 0, and every register location reads 0.
- R2: Register offsets 0, 1 and 2 hold address bits 7:0, 15:8 and 23:16. Bit 0 of offset 0 always reads 0. Offset 3 is control: bit 7 is the flag, bit 6 is the enable, and bits 5:0 read 0.
- R3: In advanced mode (`mode_adv`=1), a strobed prefetch whose bits 23:1 equal the stored address sets the flag one clock later. Address bit 0 never affects the result.
- R4: In normal mode (`mode_adv`=0), only bits 15:1 are compared. A difference in bits 23:16 still gives a hit.
- R5: A prefetch address presented while `pf_valid` is 0 never sets the flag.
- R6: While the enable bit is 0, a matching prefetch does not set the flag.
- R7: `irq` is high exactly when both the flag and the enable bit are 1. Writing the enable bit to 0 drops a pending request on the next cycle, and the flag itself is kept.
- R8: The flag is sticky. Writing 1 to bit 7 has no effect on it. Writing 0 to bit 7 without first reading the flag as 1 also has no effect.
- R9: A read of offset 3 that returns the flag as 1, followed by a write of offset 3 with bit 7 at 0, clears the flag.
- R10: If a hit and a clearing write occur in the same cycle, the flag stays set.
- R11: A mismatch in any single compared bit (1..23 in advanced mode, 1..15 in normal mode) gives no hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pf_valid | input | 1 | Instruction prefetch strobe |
| pf_addr | input | 24 | Prefetch address |
| mode_adv | input | 1 | 1: advanced (24-bit) compare, 0: normal (16-bit) compare |
| reg_sel | input | 2 | Register offset (0..2 address bytes, 3 control) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (arms flag clearing) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_sel` |
| irq | output | 1 | Level interrupt request, not maskable by the CPU |

## Verification
The assertions check four behaviours on every cycle. The flag never rises without a strobe or while the enable is 0. A hit in either mode is always followed by a set flag. Once set, the flag survives every cycle that lacks a zero-write to control. A write that clears the enable always leaves `irq` low. The bench's scenarios show the rest. These are the single-bit mismatch sweeps in both modes, the read-then-write clearing handshake and its ordering, the collision of a hit with a clear, and register readback with the forced-zero bits.

// File: rtl/pbrk_pkg.sv
// Package: shared widths and register layout of the prefetch breakpoint.
// Assumes the address width is a whole number of bytes.
package pbrk_pkg;
    localparam int ADDR_W   = 24;   // prefetch address width
    localparam int NORM_W   = 16;   // compared width in normal mode
    localparam int DATA_W   = 8;    // register port width
    localparam int FLAG_BIT = 7;    // control: match flag
    localparam int EN_BIT   = 6;    // control: break enable
endpackage

// File: rtl/pbrk_regs.sv
// Module: holds the break address bytes and the enable bit.
// Assumes ADDR_W is a multiple of DATA_W; the control register sits at
// the offset just past the address bytes.
module pbrk_regs #(
    parameter int ADDR_W = pbrk_pkg::ADDR_W,
    parameter int DATA_W = pbrk_pkg::DATA_W,
    parameter int EN_BIT = pbrk_pkg::EN_BIT,
    localparam int NBYTES = ADDR_W / DATA_W,
    localparam int SEL_W  = $clog2(NBYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] brk_addr,
    output logic              en_q
);
    localparam logic [SEL_W-1:0] CTRL_OFS = SEL_W'(NBYTES);

    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        logic [DATA_W-1:0] byte_q;
        // Purpose: store one address byte on a write to its offset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                byte_q <= '0;
            end else if (reg_wr && reg_sel == SEL_W'(i)) begin
                byte_q <= reg_wdata;
            end
        end
        if (i == 0) begin : g_low
            assign brk_addr[DATA_W-1:0] = {byte_q[DATA_W-1:1], 1'b0};
        end else begin : g_high
            assign brk_addr[i*DATA_W +: DATA_W] = byte_q;
        end
    end

    // Purpose: hold the break enable bit of the control register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (reg_wr && reg_sel == CTRL_OFS) begin
            en_q <= reg_wdata[EN_BIT];
        end
    end
endmodule

// File: rtl/pbrk_cmp.sv
// Module: qualified address compare of the prefetch bus.
// Bit 0 never takes part in the compare. In normal mode bits at and above
// NORM_W are also left out. The output is combinational.
module pbrk_cmp #(
    parameter int ADDR_W = pbrk_pkg::ADDR_W,
    parameter int NORM_W = pbrk_pkg::NORM_W
) (
    input  logic              pf_valid,
    input  logic [ADDR_W-1:0] pf_addr,
    input  logic [ADDR_W-1:0] brk_addr,
    input  logic              en,
    input  logic              mode_adv,
    output logic              hit
);
    logic [ADDR_W-1:0] care;
    logic [ADDR_W-1:0] diff;

    for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
        if (b == 0) begin : g_b0
            assign care[b] = 1'b0;
        end else if (b < NORM_W) begin : g_norm
            assign care[b] = 1'b1;
        end else begin : g_adv
            assign care[b] = mode_adv;
        end
        assign diff[b] = care[b] & (pf_addr[b] ^ brk_addr[b]);
    end

    // Purpose: a strobed, enabled prefetch with no compared difference hits.
    always_comb begin
        hit = pf_valid && en && (diff == '0);
    end
endmodule

// File: rtl/pbrk_flag.sv
// Module: sticky match flag with read-as-one then write-zero clearing.
// A hit in the same cycle as a clearing write keeps the flag set.
module pbrk_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic rd_ctrl,
    input  logic wr_ctrl,
    input  logic wr_flag_bit,
    output logic flag_q
);
    logic arm_q;

    // Purpose: remember that software has seen the flag as 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q <= 1'b0;
        end else if (wr_ctrl) begin
            arm_q <= 1'b0;
        end else if (rd_ctrl && flag_q) begin
            arm_q <= 1'b1;
        end
    end

    // Purpose: set on a hit, clear only on an armed zero-write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (hit) begin
            flag_q <= 1'b1;
        end else if (wr_ctrl && !wr_flag_bit && arm_q) begin
            flag_q <= 1'b0;
        end
    end
endmodule

// File: rtl/pbrk_top.sv
// Module: top of the prefetch address breakpoint.
// Assumes a single-cycle register port with a combinational read path.
// irq is a level output with no mask input.
module pbrk_top #(
    parameter int ADDR_W = pbrk_pkg::ADDR_W,
    parameter int NORM_W = pbrk_pkg::NORM_W,
    parameter int DATA_W = pbrk_pkg::DATA_W,
    localparam int NBYTES = ADDR_W / DATA_W,
    localparam int SEL_W  = $clog2(NBYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pf_valid,
    input  logic [ADDR_W-1:0] pf_addr,
    input  logic              mode_adv,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    localparam logic [SEL_W-1:0] CTRL_OFS = SEL_W'(NBYTES);

    logic [ADDR_W-1:0] brk_addr;
    logic              en_q;
    logic              flag_q;
    logic              hit;
    logic              sel_ctrl;

    assign sel_ctrl = (reg_sel == CTRL_OFS);

    pbrk_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .brk_addr(brk_addr), .en_q(en_q)
    );

    pbrk_cmp #(.ADDR_W(ADDR_W), .NORM_W(NORM_W)) cmp_i (
        .pf_valid(pf_valid), .pf_addr(pf_addr), .brk_addr(brk_addr),
        .en(en_q), .mode_adv(mode_adv), .hit(hit)
    );

    pbrk_flag flag_i (
        .clk(clk), .rst_n(rst_n), .hit(hit),
        .rd_ctrl(reg_rd && sel_ctrl), .wr_ctrl(reg_wr && sel_ctrl),
        .wr_flag_bit(reg_wdata[pbrk_pkg::FLAG_BIT]), .flag_q(flag_q)
    );

    // Purpose: read mux over the address bytes and the control register.
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if (reg_sel == SEL_W'(i)) reg_rdata = brk_addr[i*DATA_W +: DATA_W];
        end
        if (sel_ctrl) begin
            reg_rdata[pbrk_pkg::FLAG_BIT] = flag_q;
            reg_rdata[pbrk_pkg::EN_BIT]   = en_q;
        end
    end

    // Purpose: unmaskable request while a flagged hit is enabled.
    always_comb begin
        irq = flag_q && en_q;
    end
endmodule

// File: rtl/pbrk_chk.sv
// Module: assertion checker bound to pbrk_top; observes only.
module pbrk_chk #(
    parameter int ADDR_W = pbrk_pkg::ADDR_W,
    parameter int NORM_W = pbrk_pkg::NORM_W,
    parameter int DATA_W = pbrk_pkg::DATA_W,
    parameter int SEL_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pf_valid,
    input logic [ADDR_W-1:0] pf_addr,
    input logic              mode_adv,
    input logic [SEL_W-1:0]  reg_sel,
    input logic              reg_wr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              irq,
    input logic              flag_q,
    input logic              en_q,
    input logic [ADDR_W-1:0] brk_addr
);
    localparam logic [SEL_W-1:0] CTRL_OFS = SEL_W'(ADDR_W / DATA_W);

    logic ctrl_zero_wr;
    assign ctrl_zero_wr = reg_wr && reg_sel == CTRL_OFS && !reg_wdata[pbrk_pkg::FLAG_BIT];

    a_r3_adv_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && en_q && mode_adv && pf_addr[ADDR_W-1:1] == brk_addr[ADDR_W-1:1]) |=> flag_q);
    a_r4_norm_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && en_q && !mode_adv && pf_addr[NORM_W-1:1] == brk_addr[NORM_W-1:1]) |=> flag_q);
    a_r5_no_strobe_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!pf_valid && !flag_q) |=> !flag_q);
    a_r6_disabled_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !flag_q) |=> !flag_q);
    a_r7_disable_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == CTRL_OFS && !reg_wdata[pbrk_pkg::EN_BIT]) |=> !irq);
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !ctrl_zero_wr) |=> flag_q);
endmodule

bind pbrk_top pbrk_chk #(.ADDR_W(ADDR_W), .NORM_W(NORM_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .pf_valid(pf_valid), .pf_addr(pf_addr),
    .mode_adv(mode_adv), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .irq(irq), .flag_q(flag_q), .en_q(en_q),
    .brk_addr(brk_addr)
);

// File: tb/pbrk_top_tb_top.sv
`timescale 1ns/1ps
module pbrk_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        pf_valid;
    logic [23:0] pf_addr;
    logic        mode_adv;
    logic [1:0]  reg_sel;
    logic        reg_wr;
    logic        reg_rd;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;
    logic        irq;

    int total = 0;
    int bad   = 0;

    localparam logic [23:0] BRK = 24'hA53C7E;

    always #2.5 clk = ~clk;

    pbrk_top dut_i (
        .clk(clk), .rst_n(rst_n), .pf_valid(pf_valid), .pf_addr(pf_addr),
        .mode_adv(mode_adv), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Each task starts just after a falling edge and ends at the next one.
    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [7:0] d);
        reg_sel = sel; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic pf(input logic [23:0] a, input logic v);
        pf_addr = a; pf_valid = v;
        @(negedge clk);
        pf_valid = 1'b0;
    endtask

    task automatic clear_flag();
        logic [7:0] d;
        rd(2'd3, d);
        wr(2'd3, 8'h40);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        rst_n = 1'b0; pf_valid = 1'b0; pf_addr = '0; mode_adv = 1'b1;
        reg_sel = '0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int s = 0; s < 4; s++) begin
            rd(2'(s), d);
            check("R1 reg after reset", 32'(d), 32'h0);
        end
        check("R1 irq after reset", 32'(irq), 32'h0);

        // R2: readback, bit 0 forced to 0, control spare bits read 0
        wr(2'd0, 8'h7F); wr(2'd1, 8'h3C); wr(2'd2, 8'hA5);
        rd(2'd0, d); check("R2 low byte bit0 zero", 32'(d), 32'h7E);
        rd(2'd1, d); check("R2 mid byte", 32'(d), 32'h3C);
        rd(2'd2, d); check("R2 high byte", 32'(d), 32'hA5);
        wr(2'd3, 8'h7F);
        rd(2'd3, d); check("R2 ctrl spare bits", 32'(d), 32'h40);

        // R6: enable off blocks a matching prefetch
        wr(2'd3, 8'h00);
        pf(BRK, 1'b1);
        rd(2'd3, d); check("R6 no flag while disabled", 32'(d), 32'h00);
        wr(2'd3, 8'h40);

        // R5: no strobe, no match
        pf(BRK, 1'b0);
        rd(2'd3, d); check("R5 no flag without strobe", 32'(d), 32'h40);

        // R3, R4, R11: single-bit flip sweep in both modes
        for (int m = 0; m < 2; m++) begin
            mode_adv = m[0];
            pf(BRK | 24'h1, 1'b1);
            rd(2'd3, d);
            check(m ? "R3 exact hit bit0 ignored" : "R4 exact hit normal", 32'(d[7]), 32'h1);
            check("R7 irq on hit", 32'(irq), 32'h1);
            wr(2'd3, 8'h40);
            rd(2'd3, d); check("R9 read then zero-write clears", 32'(d[7]), 32'h0);
            for (int b = 0; b < 24; b++) begin
                logic exp_hit;
                exp_hit = (b == 0) || (m == 0 && b >= 16);
                pf(BRK ^ (24'h1 << b), 1'b1);
                rd(2'd3, d);
                if (b >= 16 && m == 0)
                    check("R4 upper byte ignored", 32'(d[7]), 32'(exp_hit));
                else if (b == 0)
                    check("R3 bit0 ignored", 32'(d[7]), 32'(exp_hit));
                else
                    check("R11 compared bit mismatch", 32'(d[7]), 32'(exp_hit));
                if (d[7]) wr(2'd3, 8'h40);
            end
        end
        mode_adv = 1'b1;

        // R7, R8: enable drop keeps flag, write of 1 has no effect
        pf(BRK, 1'b1);
        wr(2'd3, 8'h80);
        check("R7 irq drops with enable", 32'(irq), 32'h0);
        rd(2'd3, d); check("R8 flag kept after write 1", 32'(d), 32'h80);
        wr(2'd3, 8'hC0);
        check("R7 irq returns with enable", 32'(irq), 32'h1);

        // R8: zero-write without a prior read does not clear
        wr(2'd3, 8'h40);
        wr(2'd3, 8'h40);
        #1 check("R8 zero-write unarmed ignored", 32'(irq), 32'h1);

        // R10: hit and clearing write in the same cycle
        rd(2'd3, d);
        reg_sel = 2'd3; reg_wdata = 8'h40; reg_wr = 1'b1;
        pf_addr = BRK; pf_valid = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; pf_valid = 1'b0;
        rd(2'd3, d); check("R10 set wins over clear", 32'(d), 32'hC0);
        clear_flag();
        rd(2'd3, d); check("R9 clear after collision", 32'(d), 32'h40);
        check("R7 irq low after clear", 32'(irq), 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule